// File: doc/BRIEF.md
# Guarded Mapping Write Checker

This block sits in front of the write port of a 16-entry, variable-page-size address translation array. It accepts one write request at a time, made of a target slot, a virtual start address, a physical start address, a size field, an address-space bit, a process tag and an attribute word. The block decodes the size, checks the arguments, and then compares the new range with each cached mapping, one slot per clock. It drives a single-cycle commit strobe to the array only when nothing conflicts. Each request ends with a one-cycle status byte.

A negative size field requests removal of a mapping. The target slot is then written with its valid bit clear and no overlap scan takes place. The block refuses to remove the mapping that covers address zero in space 0. Writes that enable a mapping stay locked out until an initialisation pulse reports that the separate fixed-page array holds no live entries. The block keeps its own copy of every committed mapping and uses that copy for the scans.

Top module: `map_write_guard`

## Requirements
- R1: A size field from 0 to 15 selects a page of 1024·4^n bytes with n equal to the field. A field of 1024 or more is a byte count and is accepted only if it equals 1024·4^n for some n from 0 to 15. Any other non-negative field ends the request with status 0xFF (bad argument).
- R2: A negative size field is a removal. It skips the overlap scan and commits the slot with the valid output low. A successful removal keeps busy high for exactly 2 cycles.
- R3: For a non-removal request, any set bit of the virtual or physical start address below the page size gives status 0xFF.
- R4: A slot number of 16 or more gives status 0xFF. This applies to removals as well.
- R5: Two ranges conflict when the new start is at or below the old end and the new end is at or above the old start. A cached mapping is left out of the scan if it is not valid, if its space bit differs from the request's, or if its tag is nonzero and differs from the request tag.
- R6: A conflict with the slot that the request itself rewrites is ignored.
- R7: If any other slot conflicts, the block reports the lowest such slot k as status k+1 and does not commit. Busy then lasts k+2 cycles.
- R8: Until an init pulse arrives with the clean flag high, enabling writes end with status 0xFD. An init pulse with the flag low locks them again. Removals are allowed either way. A bad argument (0xFF) takes priority over 0xFD.
- R9: Every commit drives the protect output high and carries the request's slot, addresses, space, tag, decoded size selector and attributes.
- R10: A removal whose target slot holds a valid space-0 mapping starting at address 0 ends with status 0xFB and is not committed.
- R11: An accepted request raises busy on the next cycle. Busy lasts 1 cycle for a rejected argument, an uninitialised write or a refused removal, and 18 cycles for an enabling write without conflict. In the cycle where busy falls, statusValid is high for exactly one cycle. Status 0x00 means committed.
- R12: Request pulses that arrive while busy is high are ignored. They start no new request and do not change the result that is reported.
- R13: After reset, busy, statusValid and wrStrobe are low and no slot holds a valid mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initReq | input | 1 | Init pulse; latches fixedArrayClean |
| fixedArrayClean | input | 1 | High when the fixed-page array has no live entries |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqIdx | input | 5 | Target slot (values 16 and up are invalid) |
| reqEa | input | 32 | Virtual start address |
| reqPa | input | 32 | Physical start address |
| reqSize | input | 32 | Size field, signed: negative, selector or byte count |
| reqSpace | input | 1 | Address-space bit |
| reqTid | input | 12 | Process tag (0 matches any) |
| reqAttr | input | 17 | Permission and cache attribute word |
| busy | output | 1 | Request in progress |
| statusValid | output | 1 | One-cycle status strobe |
| status | output | 8 | Result code |
| wrStrobe | output | 1 | Commit strobe to the array |
| wrIdx | output | 4 | Slot written |
| wrValid | output | 1 | Valid bit written |
| wrProtect | output | 1 | Invalidate-protect bit written |
| wrSpace | output | 1 | Space bit written |
| wrTid | output | 12 | Tag written |
| wrSizeSel | output | 4 | Decoded page-size selector |
| wrEa | output | 32 | Virtual start written |
| wrPa | output | 32 | Physical start written |
| wrAttr | output | 17 | Attribute word written |

## Verification
The assertions check the handshake on every cycle. Busy rises after an accepted request and ends only together with a status strobe. The status strobe lasts a single cycle. A commit happens only while busy and is always followed by status 0x00. A conflict status never follows a commit. The result of an overlap scan can only be shown by bench scenarios: the lowest conflicting slot, the rules that leave mappings out of the scan, ranges that are adjacent but do not touch, size decoding, alignment, the init lock and the address-zero refusal. For these the bench compares the status byte, the busy length and the commit fields against a model of the cached mappings.

// File: rtl/mwg_pkg.sv
package mwg_pkg;
  localparam int SEL_W     = 4;
  localparam int NUM_SEL   = 1 << SEL_W;
  localparam int BASE_LOG2 = 10;
  // wide enough for the end address of the largest page
  localparam int SPAN_W    = BASE_LOG2 + 2 * (NUM_SEL - 1) + 2;
  localparam int STAT_W    = 8;

  localparam logic [STAT_W-1:0] CODE_OK     = 8'h00;
  localparam logic [STAT_W-1:0] CODE_BADARG = 8'hFF;
  localparam logic [STAT_W-1:0] CODE_NOINIT = 8'hFD;
  localparam logic [STAT_W-1:0] CODE_PROT   = 8'hFB;

  typedef enum logic [2:0] {
    K_OK, K_CONFLICT, K_BADARG, K_NOINIT, K_PROT
  } statKind_e;

  typedef struct packed {
    logic      capture;
    logic      scanClr;
    logic      scanStep;
    logic      commit;
    logic      report;
    statKind_e kind;
  } ctrlStrobe_t;
endpackage

// File: rtl/mwg_control.sv
module mwg_control
  import mwg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        argBad,
  input  logic        noInit,
  input  logic        isInval,
  input  logic        protHit,
  input  logic        scanHit,
  input  logic        scanLast,
  output ctrlStrobe_t ctrl,
  output logic        busy,
  output logic        wrStrobe
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_SCAN, S_COMMIT} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl      = '0;
    ctrl.kind = K_OK;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          ctrl.capture = 1'b1;
          stateNext    = S_CHECK;
        end
      end
      S_CHECK: begin
        if (argBad) begin
          ctrl.report = 1'b1;
          ctrl.kind   = K_BADARG;
          stateNext   = S_IDLE;
        end else if (noInit) begin
          ctrl.report = 1'b1;
          ctrl.kind   = K_NOINIT;
          stateNext   = S_IDLE;
        end else if (isInval) begin
          if (protHit) begin
            ctrl.report = 1'b1;
            ctrl.kind   = K_PROT;
            stateNext   = S_IDLE;
          end else begin
            stateNext = S_COMMIT;
          end
        end else begin
          ctrl.scanClr = 1'b1;
          stateNext    = S_SCAN;
        end
      end
      S_SCAN: begin
        if (scanHit) begin
          ctrl.report = 1'b1;
          ctrl.kind   = K_CONFLICT;
          stateNext   = S_IDLE;
        end else if (scanLast) begin
          stateNext = S_COMMIT;
        end else begin
          ctrl.scanStep = 1'b1;
        end
      end
      S_COMMIT: begin
        ctrl.commit = 1'b1;
        ctrl.report = 1'b1;
        ctrl.kind   = K_OK;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign wrStrobe = (state == S_COMMIT);
endmodule

// File: rtl/mwg_datapath.sv
module mwg_datapath
  import mwg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 32,
  parameter int TID_W       = 12,
  parameter int ATTR_W      = 17,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          ctrl,
  input  logic                 initReq,
  input  logic                 fixedArrayClean,
  input  logic [IDX_W:0]       reqIdx,
  input  logic [ADDR_W-1:0]    reqEa,
  input  logic [ADDR_W-1:0]    reqPa,
  input  logic [SIZE_W-1:0]    reqSize,
  input  logic                 reqSpace,
  input  logic [TID_W-1:0]     reqTid,
  input  logic [ATTR_W-1:0]    reqAttr,
  output logic                 argBad,
  output logic                 noInit,
  output logic                 isInval,
  output logic                 protHit,
  output logic                 scanHit,
  output logic                 scanLast,
  output logic                 statusValid,
  output logic [STAT_W-1:0]    status,
  output logic [IDX_W-1:0]     wrIdx,
  output logic                 wrValid,
  output logic                 wrProtect,
  output logic                 wrSpace,
  output logic [TID_W-1:0]     wrTid,
  output logic [SEL_W-1:0]     wrSizeSel,
  output logic [ADDR_W-1:0]    wrEa,
  output logic [ADDR_W-1:0]    wrPa,
  output logic [ATTR_W-1:0]    wrAttr
);
  // captured request
  logic [IDX_W:0]    rIdx;
  logic [ADDR_W-1:0] rEa, rPa;
  logic [SIZE_W-1:0] rSize;
  logic              rSpace;
  logic [TID_W-1:0]  rTid;
  logic [ATTR_W-1:0] rAttr;
  logic              initialized;
  logic [IDX_W-1:0]  scanIdx;

  // cached copy of the array
  logic              cValid [NUM_ENTRIES];
  logic              cSpace [NUM_ENTRIES];
  logic [TID_W-1:0]  cTid   [NUM_ENTRIES];
  logic [SEL_W-1:0]  cSel   [NUM_ENTRIES];
  logic [ADDR_W-1:0] cEa    [NUM_ENTRIES];

  logic [IDX_W-1:0]       tIdx;
  logic                   sizeOk, misAlign, idxBad;
  logic [SEL_W-1:0]       selDec;
  logic [SPAN_W-1:0]      pageBytes, newStart, newEnd, oldStart, oldEnd;
  logic [NUM_ENTRIES-1:0] entryWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rIdx <= '0; rEa <= '0; rPa <= '0; rSize <= '0;
      rSpace <= 1'b0; rTid <= '0; rAttr <= '0;
    end else if (ctrl.capture) begin
      rIdx <= reqIdx; rEa <= reqEa; rPa <= reqPa; rSize <= reqSize;
      rSpace <= reqSpace; rTid <= reqTid; rAttr <= reqAttr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        initialized <= 1'b0;
    else if (initReq) initialized <= fixedArrayClean;
  end

  // size field decode: negative, selector, or exact byte count
  always_comb begin
    isInval = rSize[SIZE_W-1];
    sizeOk  = 1'b0;
    selDec  = '0;
    if (!isInval) begin
      if (rSize < SIZE_W'(NUM_SEL)) begin
        sizeOk = 1'b1;
        selDec = rSize[SEL_W-1:0];
      end else begin
        for (int n = 0; n < NUM_SEL; n++) begin
          if (SPAN_W'(rSize) == (SPAN_W'(1) << (BASE_LOG2 + 2 * n))) begin
            sizeOk = 1'b1;
            selDec = SEL_W'(n);
          end
        end
      end
    end
  end

  assign tIdx      = rIdx[IDX_W-1:0];
  assign pageBytes = SPAN_W'(1) << (BASE_LOG2 + 2 * int'(selDec));
  assign misAlign  = |((SPAN_W'(rEa) | SPAN_W'(rPa)) & (pageBytes - SPAN_W'(1)));
  assign idxBad    = rIdx >= (IDX_W+1)'(NUM_ENTRIES);
  assign argBad    = idxBad | (!isInval & (!sizeOk | misAlign));
  assign noInit    = !isInval & !initialized;
  assign protHit   = cValid[tIdx] & !cSpace[tIdx] & (cEa[tIdx] == '0);

  // one candidate per clock
  assign newStart = SPAN_W'(rEa);
  assign newEnd   = newStart + pageBytes - SPAN_W'(1);
  assign oldStart = SPAN_W'(cEa[scanIdx]);
  assign oldEnd   = oldStart + (SPAN_W'(1) << (BASE_LOG2 + 2 * int'(cSel[scanIdx]))) - SPAN_W'(1);
  assign scanHit  = cValid[scanIdx]
                  & (cSpace[scanIdx] == rSpace)
                  & ((cTid[scanIdx] == '0) | (cTid[scanIdx] == rTid))
                  & (scanIdx != tIdx)
                  & (newStart <= oldEnd)
                  & (newEnd >= oldStart);
  assign scanLast = (scanIdx == IDX_W'(NUM_ENTRIES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              scanIdx <= '0;
    else if (ctrl.scanClr)  scanIdx <= '0;
    else if (ctrl.scanStep) scanIdx <= scanIdx + IDX_W'(1);
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_we
    assign entryWe[e] = ctrl.commit & (tIdx == IDX_W'(e));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        cValid[e] <= 1'b0; cSpace[e] <= 1'b0; cTid[e] <= '0;
        cSel[e] <= '0; cEa[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (entryWe[e]) begin
          cValid[e] <= !isInval;
          if (!isInval) begin
            cSpace[e] <= rSpace; cTid[e] <= rTid;
            cSel[e] <= selDec;   cEa[e] <= rEa;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusValid <= 1'b0;
      status      <= CODE_OK;
    end else begin
      statusValid <= ctrl.report;
      if (ctrl.report) begin
        unique case (ctrl.kind)
          K_CONFLICT: status <= STAT_W'(scanIdx) + STAT_W'(1);
          K_BADARG:   status <= CODE_BADARG;
          K_NOINIT:   status <= CODE_NOINIT;
          K_PROT:     status <= CODE_PROT;
          default:    status <= CODE_OK;
        endcase
      end
    end
  end

  assign wrIdx     = tIdx;
  assign wrValid   = !isInval;
  assign wrProtect = 1'b1;
  assign wrSpace   = rSpace;
  assign wrTid     = rTid;
  assign wrSizeSel = selDec;
  assign wrEa      = rEa;
  assign wrPa      = rPa;
  assign wrAttr    = rAttr;
endmodule

// File: rtl/map_write_guard.sv
module map_write_guard
  import mwg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 32,
  parameter int TID_W       = 12,
  parameter int ATTR_W      = 17,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic              fixedArrayClean,
  input  logic              reqValid,
  input  logic [IDX_W:0]    reqIdx,
  input  logic [ADDR_W-1:0] reqEa,
  input  logic [ADDR_W-1:0] reqPa,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqSpace,
  input  logic [TID_W-1:0]  reqTid,
  input  logic [ATTR_W-1:0] reqAttr,
  output logic              busy,
  output logic              statusValid,
  output logic [7:0]        status,
  output logic              wrStrobe,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              wrValid,
  output logic              wrProtect,
  output logic              wrSpace,
  output logic [TID_W-1:0]  wrTid,
  output logic [3:0]        wrSizeSel,
  output logic [ADDR_W-1:0] wrEa,
  output logic [ADDR_W-1:0] wrPa,
  output logic [ATTR_W-1:0] wrAttr
);
  ctrlStrobe_t ctrl;
  logic argBad, noInit, isInval, protHit, scanHit, scanLast;

  mwg_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .argBad(argBad), .noInit(noInit), .isInval(isInval), .protHit(protHit),
    .scanHit(scanHit), .scanLast(scanLast),
    .ctrl(ctrl), .busy(busy), .wrStrobe(wrStrobe)
  );

  mwg_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .TID_W(TID_W), .ATTR_W(ATTR_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .initReq(initReq), .fixedArrayClean(fixedArrayClean),
    .reqIdx(reqIdx), .reqEa(reqEa), .reqPa(reqPa), .reqSize(reqSize),
    .reqSpace(reqSpace), .reqTid(reqTid), .reqAttr(reqAttr),
    .argBad(argBad), .noInit(noInit), .isInval(isInval), .protHit(protHit),
    .scanHit(scanHit), .scanLast(scanLast),
    .statusValid(statusValid), .status(status),
    .wrIdx(wrIdx), .wrValid(wrValid), .wrProtect(wrProtect), .wrSpace(wrSpace),
    .wrTid(wrTid), .wrSizeSel(wrSizeSel), .wrEa(wrEa), .wrPa(wrPa), .wrAttr(wrAttr)
  );
endmodule

// File: rtl/mwg_checker.sv
module mwg_checker #(
  parameter int NUM_ENTRIES = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       busy,
  input logic       statusValid,
  input logic [7:0] status,
  input logic       wrStrobe
);
  p_accept_raises_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  p_status_single_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid);

  p_status_after_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> !busy);

  p_busy_ends_with_status_r12: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || statusValid));

  p_commit_inside_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> busy);

  p_commit_reports_ok_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> (statusValid && status == 8'h00));

  p_conflict_no_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && status != 8'h00 && status <= 8'(NUM_ENTRIES)) |-> !$past(wrStrobe));
endmodule

bind map_write_guard mwg_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .statusValid(statusValid), .status(status), .wrStrobe(wrStrobe)
);

// File: tb/sim_map_write_guard.sv
module sim_map_write_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initReq = 1'b0, fixedArrayClean = 1'b0;
  logic        reqValid = 1'b0;
  logic [4:0]  reqIdx = '0;
  logic [31:0] reqEa = '0, reqPa = '0, reqSize = '0;
  logic        reqSpace = 1'b0;
  logic [11:0] reqTid = '0;
  logic [16:0] reqAttr = '0;
  logic        busy, statusValid, wrStrobe, wrValid, wrProtect, wrSpace;
  logic [7:0]  status;
  logic [3:0]  wrIdx, wrSizeSel;
  logic [11:0] wrTid;
  logic [31:0] wrEa, wrPa;
  logic [16:0] wrAttr;

  int nChecks = 0, nFails = 0;

  // bench model of the cached mappings
  bit          mInit = 0;
  bit          mV [16];
  bit          mS [16];
  logic [11:0] mT [16];
  int          mSel [16];
  logic [31:0] mEa [16];

  always #2 clk = ~clk;

  map_write_guard u0 (
    .clk(clk), .rstN(rstN), .initReq(initReq), .fixedArrayClean(fixedArrayClean),
    .reqValid(reqValid), .reqIdx(reqIdx), .reqEa(reqEa), .reqPa(reqPa),
    .reqSize(reqSize), .reqSpace(reqSpace), .reqTid(reqTid), .reqAttr(reqAttr),
    .busy(busy), .statusValid(statusValid), .status(status), .wrStrobe(wrStrobe),
    .wrIdx(wrIdx), .wrValid(wrValid), .wrProtect(wrProtect), .wrSpace(wrSpace),
    .wrTid(wrTid), .wrSizeSel(wrSizeSel), .wrEa(wrEa), .wrPa(wrPa), .wrAttr(wrAttr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic predict(input int idx, input logic [31:0] ea, input logic [31:0] pa,
                         input int size, input bit sp, input logic [11:0] tid,
                         output logic [7:0] st, output int cyc, output bit com,
                         output int sel, output bit inval);
    bit ok;
    longint b, nS, nE, oS, oE;
    inval = (size < 0); ok = 0; sel = 0; com = 0;
    if (!inval) begin
      if (size < 16) begin ok = 1; sel = size; end
      else for (int n = 0; n < 16; n++)
        if (longint'(size) == (longint'(1) << (10 + 2*n))) begin ok = 1; sel = n; end
    end
    b = longint'(1) << (10 + 2*sel);
    if (idx > 15) begin st = 8'hFF; cyc = 1; end
    else if (!inval && (!ok || ((longint'(ea) | longint'(pa)) & (b - 1)) != 0)) begin
      st = 8'hFF; cyc = 1;
    end else if (!inval && !mInit) begin st = 8'hFD; cyc = 1; end
    else if (inval) begin
      if (mV[idx] && !mS[idx] && mEa[idx] == 32'h0) begin st = 8'hFB; cyc = 1; end
      else begin st = 8'h00; cyc = 2; com = 1; end
    end else begin
      st = 8'h00; cyc = 18; com = 1;
      nS = longint'(ea); nE = nS + b - 1;
      for (int k = 0; k < 16; k++) begin
        if (com && k != idx && mV[k] && mS[k] == sp && (mT[k] == 12'h0 || mT[k] == tid)) begin
          oS = longint'(mEa[k]);
          oE = oS + (longint'(1) << (10 + 2*mSel[k])) - 1;
          if (nS <= oE && nE >= oS) begin st = 8'(k + 1); cyc = k + 2; com = 0; end
        end
      end
    end
  endtask

  task automatic doInit(input bit clean);
    @(negedge clk);
    initReq = 1'b1; fixedArrayClean = clean;
    @(negedge clk);
    initReq = 1'b0;
    mInit = clean;
  endtask

  task automatic runReq(input string tag, input int idx, input logic [31:0] ea,
                        input logic [31:0] pa, input int size, input bit sp,
                        input logic [11:0] tid, input bit poke);
    logic [7:0] expSt;
    int expCyc, expSel, cyc;
    bit expCom, inval, sawWr;
    logic [3:0] gIdx, gSel;
    logic gValid, gProt;
    logic [31:0] gEa;
    predict(idx, ea, pa, size, sp, tid, expSt, expCyc, expCom, expSel, inval);
    @(negedge clk);
    reqValid = 1'b1; reqIdx = 5'(idx); reqEa = ea; reqPa = pa; reqSize = size;
    reqSpace = sp; reqTid = tid; reqAttr = 17'($urandom);
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin
      reqValid = 1'b1; reqIdx = 5'd20; reqSize = 32'd100; reqEa = 32'h3;
    end
    cyc = 0; sawWr = 0;
    gIdx = '0; gSel = '0; gValid = 1'b0; gProt = 1'b0; gEa = '0;
    while (busy && cyc < 40) begin
      cyc++;
      if (wrStrobe) begin
        sawWr = 1; gIdx = wrIdx; gSel = wrSizeSel; gValid = wrValid; gProt = wrProtect; gEa = wrEa;
      end
      @(negedge clk);
      reqValid = 1'b0;
    end
    chk(cyc < 40, {tag, " R11 watchdog"}, cyc, expCyc);
    chk(statusValid === 1'b1, {tag, " R11 statusValid"}, statusValid, 1);
    chk(status === expSt, {tag, " status"}, status, expSt);
    chk(cyc == expCyc, {tag, " R11 busy cycles"}, cyc, expCyc);
    chk(sawWr == expCom, {tag, " R7 commit seen"}, sawWr, expCom);
    if (expCom && sawWr) begin
      chk(gProt === 1'b1, {tag, " R9 protect"}, gProt, 1);
      chk(gIdx == 4'(idx), {tag, " R9 slot"}, gIdx, idx);
      chk(gValid == !inval, {tag, " R2 valid bit"}, gValid, !inval);
      if (!inval) begin
        chk(gEa == ea, {tag, " R9 ea"}, gEa, ea);
        chk(gSel == 4'(expSel), {tag, " R1 size sel"}, gSel, expSel);
      end
    end
    if (poke) begin
      @(negedge clk);
      chk(busy === 1'b0, {tag, " R12 busy stays low"}, busy, 0);
    end
    if (expCom) begin
      if (inval) mV[idx] = 0;
      else begin
        mV[idx] = 1; mS[idx] = sp; mT[idx] = tid; mSel[idx] = expSel; mEa[idx] = ea;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    for (int i = 0; i < 16; i++) begin mV[i] = 0; mS[i] = 0; mT[i] = 0; mSel[i] = 0; mEa[i] = 0; end
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(busy === 1'b0, "R13 busy", busy, 0);
    chk(statusValid === 1'b0, "R13 statusValid", statusValid, 0);
    chk(wrStrobe === 1'b0, "R13 wrStrobe", wrStrobe, 0);
    rstN = 1'b1;
    // R8 locked before init; removal allowed; dirty init keeps lock
    runReq("R8 before init", 1, 32'h4000, 32'h0, 0, 0, 0, 0);
    runReq("R8 R2 removal before init", 3, 32'h0, 32'h0, -1, 0, 0, 0);
    doInit(0);
    runReq("R8 dirty init", 1, 32'h4000, 32'h0, 0, 0, 0, 0);
    runReq("R8 badarg wins", 1, 32'h4000, 32'h0, 500, 0, 0, 0);
    doInit(1);
    // R1 size decode
    runReq("R1 size 100", 1, 32'h0, 32'h0, 100, 0, 0, 0);
    runReq("R1 size 2048", 1, 32'h0, 32'h0, 2048, 0, 0, 0);
    runReq("R1 size 4096", 4, 32'h0100_0000, 32'h0, 4096, 0, 0, 0);
    // R3 alignment, R4 index
    runReq("R3 ea misaligned", 6, 32'h0000_0400, 32'h0, 1, 0, 0, 0);
    runReq("R3 pa misaligned", 6, 32'h0000_1000, 32'h0000_0800, 1, 0, 0, 0);
    runReq("R4 index 16", 16, 32'h0, 32'h0, 0, 0, 0, 0);
    runReq("R4 removal index 17", 17, 32'h0, 32'h0, -1, 0, 0, 0);
    // main scan, R12 poke during busy
    runReq("R11 clean write", 0, 32'h0, 32'h0, 2, 0, 0, 1);
    runReq("R5 R7 conflict slot0", 5, 32'h2000, 32'h0, 0, 0, 0, 1);
    runReq("R5 space differs", 5, 32'h2000, 32'h0, 0, 1, 0, 0);
    runReq("R6 self rewrite", 0, 32'h0, 32'h0, 1, 0, 0, 0);
    runReq("R5 tagged entry", 2, 32'h0010_0000, 32'h0, 1, 0, 12'h7, 0);
    runReq("R5 tag differs", 7, 32'h0010_0000, 32'h0, 0, 0, 12'h3, 0);
    runReq("R5 tag equal", 8, 32'h0010_0400, 32'h0, 0, 0, 12'h7, 0);
    runReq("R5 adjacent", 9, 32'h0010_1000, 32'h0, 0, 0, 12'h7, 0);
    runReq("R5 last byte", 10, 32'h0010_0C00, 32'h0, 0, 0, 12'h7, 0);
    runReq("R7 lowest slot", 11, 32'h0, 32'h0, 6, 1, 0, 0);
    runReq("R10 remove zero page", 0, 32'h0, 32'h0, -1, 0, 0, 0);
    runReq("R2 remove slot2", 2, 32'h0, 32'h0, -1, 0, 0, 1);
    runReq("R2 freed range", 12, 32'h0010_0000, 32'h0, 0, 0, 12'h7, 0);
    // random mix
    for (int i = 0; i < 300; i++) begin
      int idx, sel, size, r;
      logic [31:0] ea, pa;
      idx = $urandom % 18;
      sel = $urandom % 4;
      ea = 32'($urandom % 8) << (10 + 2*sel);
      pa = 32'($urandom % 8) << (10 + 2*sel);
      r = $urandom % 16;
      size = sel;
      if (r < 2) size = -1;
      else if (r < 4) size = 1024 << (2*sel);
      else if (r == 4) size = 500;
      else if (r == 5) ea = ea | 32'h400;
      runReq("random", idx, ea, pa, size, 1'($urandom), 12'($urandom % 3), 1'($urandom % 4 == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule